// File: doc/BRIEF.md
# Operand Forwarding and Load Interlock Unit

This block decides, for a five-stage pipeline (fetch, decode, execute, buffer/data, write-back), where each of the three source operands of an instruction should come from as it enters execute. There are three possible sources: the register file, the result register at the end of execute, or the result register at the end of the buffer/data stage. It compares the source register numbers of the instruction in decode with the destination numbers of the two instructions ahead of it. From that comparison it produces one registered select per operand. These selects are valid for the cycle in which that instruction occupies execute.

The block also finds the one hazard that forwarding cannot cover: a load followed at once by an instruction that reads the loaded register. In that cycle it raises a combinational hold for the fetch and decode registers and a squash that turns the incoming execute slot into a bubble. The bubble's write-enables are cleared outside this block. The bubble slot's selects are forced to the register file. One cycle later the load sits in the buffer/data stage, and its data is forwarded from that stage's result register.

Top module: `fwd_hazard_unit`

## Requirements
- R1: After reset every operand select reads 0 (register file) and, with all write-enables low, hold and squash are low.
- R2: When a used decode source equals the execute-stage destination, that producer has its write-enable set and is not a load, and there is no stall, the operand's select is 1 (execute result register) in the next cycle.
- R3: When a used decode source equals the buffer/data-stage destination with its write-enable set, and the execute stage does not match, the select is 2 (buffer/data result register) in the next cycle.
- R4: When both stages match the same source, the younger execute-stage result wins (select 1).
- R5: A producer with its write-enable clear is never forwarded from and never causes a stall.
- R6: Register number PC_REG (default 15, the program counter) is never forwarded and never causes a stall.
- R7: A load in execute whose destination equals a used decode source raises hold and squash in that same cycle, and all selects read 0 in the following cycle.
- R8: A load in execute whose destination no used decode source reads causes no hold or squash.
- R9: On the cycle after the stall, with the load now in buffer/data and a bubble in execute, the dependent operand's select is 2 and no further stall occurs.
- R10: Each of the three operands (operand i at id_src bits [i*RW +: RW], select at fwd_sel bits [2*i +: 2]) is resolved independently, so different operands may take different sources in the same cycle.
- R11: A source whose use flag is 0 selects 0 and cannot cause a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_src | input | NSRC*RW | Source register numbers of the decode-stage instruction |
| id_use | input | NSRC | Per-source flag: the operand is actually read |
| ex_dst | input | RW | Destination register of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | RW | Destination register of the buffer/data-stage instruction |
| mem_we | input | 1 | Buffer/data-stage instruction writes a register |
| fwd_sel | output | 2*NSRC | Registered per-operand select for the execute-stage instruction |
| front_hold | output | 1 | Hold the fetch and decode registers this cycle |
| ex_squash | output | 1 | Load a bubble into the execute stage this cycle |

## Verification
Single-stage matches on one operand separate the two forwarding paths. A case where both stages write the same register shows whether the younger-first priority holds. A case that mixes sources across the three operands exposes any crossed operand wiring. Producers with their write-enable clear, reads of the program-counter number and unused sources check that false matches are suppressed. A load followed by a dependent read is stepped through the stall and the bubble cycle. That sequence confirms a single stall cycle followed by forwarding from the later stage. Loads that are not used, or are used only two instructions later, must pass without any hold.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'd0,
    SEL_EXMEM = 2'd1,
    SEL_MEMWB = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/fwd_operand_match.sv
module fwd_operand_match
  import fwd_pkg::*;
#(
  parameter int RW     = 4,
  parameter int PC_REG = 15
) (
  input  logic [RW-1:0] src,
  input  logic          use_i,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_we,
  output fwd_sel_e      sel_next,
  output logic          load_hit
);
  localparam logic [RW-1:0] PC_ID = PC_REG[RW-1:0];

  logic src_ok, ex_hit, mem_hit;

  always_comb begin
    src_ok   = use_i && (src != PC_ID);
    ex_hit   = src_ok && ex_we && (src == ex_dst);
    mem_hit  = src_ok && mem_we && (src == mem_dst);
    load_hit = ex_hit && ex_load;
    if (ex_hit)       sel_next = SEL_EXMEM;   // younger result first
    else if (mem_hit) sel_next = SEL_MEMWB;
    else              sel_next = SEL_RF;
  end
endmodule

// File: rtl/fwd_load_interlock.sv
module fwd_load_interlock #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] load_hits,
  output logic            stall
);
  always_comb stall = |load_hits;
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fwd_pkg::*;
#(
  parameter int RW     = 4,
  parameter int NSRC   = 3,
  parameter int PC_REG = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC*RW-1:0]   id_src,
  input  logic [NSRC-1:0]      id_use,
  input  logic [RW-1:0]        ex_dst,
  input  logic                 ex_we,
  input  logic                 ex_load,
  input  logic [RW-1:0]        mem_dst,
  input  logic                 mem_we,
  output logic [2*NSRC-1:0]    fwd_sel,
  output logic                 front_hold,
  output logic                 ex_squash
);
  localparam logic [RW-1:0] PC_ID = PC_REG[RW-1:0];

  logic [NSRC-1:0] load_hits;
  logic            stall;

  fwd_load_interlock #(.NSRC(NSRC)) u_lock (
    .load_hits(load_hits),
    .stall    (stall)
  );

  assign front_hold = stall;
  assign ex_squash  = stall;

  // stall is only ever caused by a writing load in execute
  assert_stall_cause_R8: assert property (@(posedge clk) disable iff (rst)
    stall |-> (ex_load && ex_we));

  for (genvar i = 0; i < NSRC; i++) begin : g_op
    fwd_sel_e        nxt;
    fwd_sel_e        sel_q;
    logic [RW-1:0]   src_i;

    assign src_i = id_src[i*RW +: RW];

    fwd_operand_match #(.RW(RW), .PC_REG(PC_REG)) u_match (
      .src     (src_i),
      .use_i   (id_use[i]),
      .ex_dst  (ex_dst),
      .ex_we   (ex_we),
      .ex_load (ex_load),
      .mem_dst (mem_dst),
      .mem_we  (mem_we),
      .sel_next(nxt),
      .load_hit(load_hits[i])
    );

    always_ff @(posedge clk) begin
      if (rst || stall) sel_q <= SEL_RF;   // bubble slot reads nothing forwarded
      else              sel_q <= nxt;
    end

    assign fwd_sel[2*i +: 2] = sel_q;

    assert_sel_legal_R10: assert property (@(posedge clk) disable iff (rst)
      sel_q != fwd_sel_e'(2'd3));

    assert_ex_fwd_R2: assert property (@(posedge clk) disable iff (rst)
      (id_use[i] && ex_we && !ex_load && src_i == ex_dst && src_i != PC_ID && !stall)
      |=> (fwd_sel[2*i +: 2] == 2'd1));

    assert_pc_block_R6: assert property (@(posedge clk) disable iff (rst)
      (src_i == PC_ID) |=> (fwd_sel[2*i +: 2] == 2'd0));

    assert_unused_R11: assert property (@(posedge clk) disable iff (rst)
      !id_use[i] |=> (fwd_sel[2*i +: 2] == 2'd0));

    assert_bubble_R7: assert property (@(posedge clk) disable iff (rst)
      front_hold |=> (fwd_sel[2*i +: 2] == 2'd0));
  end
endmodule

// File: tb/test_fwd_hazard_unit.sv
module test_fwd_hazard_unit;
  localparam int RW = 4;
  localparam int NSRC = 3;

  logic clk = 0;
  logic rst;
  logic [NSRC*RW-1:0] id_src;
  logic [NSRC-1:0] id_use;
  logic [RW-1:0] ex_dst, mem_dst;
  logic ex_we, ex_load, mem_we;
  logic [2*NSRC-1:0] fwd_sel;
  logic front_hold, ex_squash;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;   // 250 MHz

  fwd_hazard_unit #(.RW(RW), .NSRC(NSRC), .PC_REG(15)) i_fwd_hazard_unit (
    .clk(clk), .rst(rst), .id_src(id_src), .id_use(id_use),
    .ex_dst(ex_dst), .ex_we(ex_we), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_we(mem_we),
    .fwd_sel(fwd_sel), .front_hold(front_hold), .ex_squash(ex_squash)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // apply inputs after a falling edge
  task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
                       input logic [2:0] u, input logic [3:0] ed, input logic ew,
                       input logic el, input logic [3:0] md, input logic mw);
    @(negedge clk);
    id_src = {c, b, a}; id_use = u;
    ex_dst = ed; ex_we = ew; ex_load = el;
    mem_dst = md; mem_we = mw;
    #1;
  endtask

  // after the next rising edge, look at registered selects
  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  function automatic int sel(input int i);
    return int'(fwd_sel[2*i +: 2]);
  endfunction

  task automatic t_reset();
    rst = 1;
    drive(0, 0, 0, 3'b000, 0, 0, 0, 0, 0);
    after_edge(); after_edge();
    for (int i = 0; i < NSRC; i++) chk(sel(i), 0, "R1 sel after reset");
    chk(front_hold, 0, "R1 hold after reset");
    chk(ex_squash, 0, "R1 squash after reset");
    rst = 0;
  endtask

  task automatic t_ex_fwd();
    drive(3, 1, 9, 3'b111, 3, 1, 0, 0, 0);
    chk(front_hold, 0, "R2 no stall for alu producer");
    after_edge();
    chk(sel(0), 1, "R2 operand a from execute result");
    chk(sel(1), 0, "R2 operand b register file");
    drive(1, 2, 8, 3'b111, 8, 1, 0, 0, 0);
    after_edge();
    chk(sel(2), 1, "R10 operand c from execute result");
    chk(sel(0), 0, "R10 operand a untouched");
  endtask

  task automatic t_mem_fwd();
    drive(1, 5, 2, 3'b111, 7, 1, 0, 5, 1);
    after_edge();
    chk(sel(1), 2, "R3 operand b from data-stage result");
    chk(sel(0), 0, "R3 operand a register file");
  endtask

  task automatic t_priority();
    drive(6, 1, 6, 3'b111, 6, 1, 0, 6, 1);
    after_edge();
    chk(sel(0), 1, "R4 younger wins operand a");
    chk(sel(2), 1, "R4 younger wins operand c");
    drive(6, 7, 6, 3'b111, 6, 1, 0, 7, 1);
    after_edge();
    chk(sel(0), 1, "R10 mixed operand a");
    chk(sel(1), 2, "R10 mixed operand b");
    chk(sel(2), 1, "R10 mixed operand c");
  endtask

  task automatic t_no_we();
    drive(4, 4, 1, 3'b111, 4, 0, 1, 4, 0);
    chk(front_hold, 0, "R5 non-writing load no stall");
    after_edge();
    chk(sel(0), 0, "R5 no forward without write-enable");
    chk(sel(1), 0, "R5 no forward without write-enable b");
  endtask

  task automatic t_pc();
    drive(15, 15, 1, 3'b111, 15, 1, 1, 0, 0);
    chk(front_hold, 0, "R6 pc load no stall");
    after_edge();
    chk(sel(0), 0, "R6 pc not forwarded");
    drive(15, 1, 1, 3'b111, 0, 0, 0, 15, 1);
    after_edge();
    chk(sel(0), 0, "R6 pc not forwarded from data stage");
  endtask

  task automatic t_unused();
    drive(2, 2, 2, 3'b000, 2, 1, 1, 2, 1);
    chk(front_hold, 0, "R11 unused source no stall");
    after_edge();
    for (int i = 0; i < NSRC; i++) chk(sel(i), 0, "R11 unused source register file");
  endtask

  task automatic t_load_use();
    // load r2 in execute, decode reads r2 on operand a, r9 matches data stage on b
    drive(2, 9, 3, 3'b111, 2, 1, 1, 9, 1);
    chk(front_hold, 1, "R7 hold on load-use");
    chk(ex_squash, 1, "R7 squash on load-use");
    after_edge();
    for (int i = 0; i < NSRC; i++) chk(sel(i), 0, "R7 bubble selects register file");
    // load moved to data stage, bubble in execute, same decode instruction
    drive(2, 9, 3, 3'b111, 0, 0, 0, 2, 1);
    chk(front_hold, 0, "R9 single stall cycle");
    after_edge();
    chk(sel(0), 2, "R9 loaded value from data stage");
    chk(sel(1), 0, "R9 operand b register file");
  endtask

  task automatic t_load_no_use();
    drive(1, 3, 4, 3'b111, 2, 1, 1, 0, 0);
    chk(front_hold, 0, "R8 unused load no stall");
    chk(ex_squash, 0, "R8 unused load no squash");
    after_edge();
    for (int i = 0; i < NSRC; i++) chk(sel(i), 0, "R8 selects after unused load");
    drive(1, 2, 4, 3'b111, 5, 1, 0, 2, 1);
    chk(front_hold, 0, "R8 load two ahead no stall");
    after_edge();
    chk(sel(1), 2, "R8 load two ahead forwarded");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ex_fwd();
    t_mem_fwd();
    t_priority();
    t_no_we();
    t_pc();
    t_unused();
    t_load_use();
    t_load_no_use();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule